// File: doc/BRIEF.md
# Packed-Subword Multiply-Add Unit

This block is the datapath for one packed-subword multiply-accumulate operation. From each of two 32-bit source words it selects one byte or one halfword as a multiplier operand. Each operand is sign-extended or zero-extended according to its own signedness flag. The unit multiplies the two operands and adds a 32-bit addend. It can then shift the sum right by 7 or 15 and clamp it to the 32-bit range. The result comes out one clock after the request, together with a write strobe and, when asked for, updated condition flags.

The second multiplier operand is taken either from a register word, through the same byte/halfword selection as the first, or from a 16-bit immediate. The surrounding pipeline supplies already-decoded control fields. A size code that this unit does not handle forces a zero result. The full-word size code also raises an illegal-operation output.

Top module: `psmad_unit`

## Requirements
- R1: With `a_byte`/`b_byte` set, the operand is the 8-bit field at bits [lane*8+7 : lane*8] of its source word, where lane is `a_lane`/`b_lane` (0 = least significant byte).
- R2: In halfword mode, size code 0 selects bits [15:0] and size code 1 selects bits [31:16] of the source word.
- R3: An operand whose signed flag is set is sign-extended from its 8 or 16 bits; otherwise it is zero-extended. The result is treated as signed when either operand flag is set.
- R4: With `b_from_reg` low, operand B is `imm_b`. It is sign-extended only when `b_sign` is set, and the B size code is then ignored.
- R5: The sum is A×B + C. C (`src_c`) is sign-extended when the result is signed and zero-extended otherwise.
- R6: Shift code 1 shifts the sum arithmetically right by 7. Code 2 shifts it right by 15. Codes 0 and 3 apply no shift.
- R7: With `sat_en` set, a value above the maximum of the result's 32-bit range (0x7FFFFFFF signed, 0xFFFFFFFF unsigned) is clamped to that maximum. A value below the minimum (0x80000000 signed, 0 unsigned) is clamped to that minimum. Either clamp sets the saturated flag. Without `sat_en` the low 32 bits are kept.
- R8: In halfword mode, size code 3 on A, or on B when B comes from a register, forces the result to zero and `illegal` low. A size code in byte mode has no effect.
- R9: Size code 2 (full word) on A, or on register-sourced B, forces the result to zero and drives `illegal` high.
- R10: `out_valid`, `result` and `illegal` appear on the clock edge after `in_valid`. Reset drives all outputs to zero. `result` and `illegal` hold while no request arrives.
- R11: When a request has `flag_en` set, `flag_zero` = (result == 0), `flag_neg` = result[31], and `flag_sat` follows R7 (0 for a forced-zero result). When `flag_en` is clear, all three flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 32 | Source word for operand A |
| src_b | input | 32 | Source word for operand B |
| imm_b | input | 16 | Immediate for operand B |
| src_c | input | 32 | Addend |
| b_from_reg | input | 1 | 1: B from `src_b`, 0: B from `imm_b` |
| a_sign | input | 1 | Operand A signed |
| b_sign | input | 1 | Operand B signed |
| a_byte | input | 1 | A byte mode |
| a_lane | input | 2 | A byte lane |
| a_size | input | 2 | A size code (0 low half, 1 high half, 2 word, 3 invalid) |
| b_byte | input | 1 | B byte mode |
| b_lane | input | 2 | B byte lane |
| b_size | input | 2 | B size code |
| shift_sel | input | 2 | Shift code (0 none, 1 by 7, 2 by 15, 3 none) |
| sat_en | input | 1 | Saturation enable |
| flag_en | input | 1 | Update condition flags |
| out_valid | output | 1 | Result write strobe |
| result | output | 32 | Result |
| illegal | output | 1 | Unsupported full-word size used |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result bit 31 |
| flag_sat | output | 1 | Saturation clamped the result |

## Verification
Several operand patterns are used, and each one separates a different fault.
- Byte lanes carrying distinct values show whether the correct lane is picked; high and low halves of the same word show whether the correct half is picked.
- Negative chunks multiplied with and without their signed flag set expose a wrong sign or zero extension.
- An all-ones immediate and an addend of 0x80000000 under a shift make the signed and unsigned interpretations of B and C produce visibly different results.
- Sums just beyond each end of the signed and unsigned ranges are run with saturation on and off.
- The invalid and word size codes are applied both where they take effect and where they must be ignored.
- A request with `flag_en` clear follows a flag-setting request, to show that the flags are held.

// File: rtl/psmad_pkg.sv
package psmad_pkg;

  typedef enum logic [1:0] {
    SZ_HALF_LO = 2'd0,
    SZ_HALF_HI = 2'd1,
    SZ_WORD    = 2'd2,
    SZ_BAD     = 2'd3
  } psmad_size_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_R7    = 2'd1,
    SH_R15   = 2'd2,
    SH_NONE3 = 2'd3
  } psmad_shift_e;

endpackage

// File: rtl/psmad_extract.sv
module psmad_extract
  import psmad_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int OPND_W = HALF_W + 1,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int SEL_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] src,
  input  logic              byte_mode,
  input  logic [SEL_W-1:0]  lane,
  input  logic [1:0]        size,
  input  logic              is_signed,
  output logic [OPND_W-1:0] opnd,
  output logic              word_sel,
  output logic              bad_sel
);

  logic [BYTE_W-1:0] lane_val [LANES];
  logic [BYTE_W-1:0] byte_pick;
  logic [HALF_W-1:0] half_pick;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_val[g] = src[g*BYTE_W +: BYTE_W];
  end

  assign byte_pick = lane_val[lane];
  assign half_pick = (psmad_size_e'(size) == SZ_HALF_HI) ? src[DATA_W-1:HALF_W]
                                                         : src[HALF_W-1:0];

  always_comb begin
    word_sel = 1'b0;
    bad_sel  = 1'b0;
    opnd     = '0;
    if (byte_mode) begin
      opnd = {{(OPND_W-BYTE_W){is_signed & byte_pick[BYTE_W-1]}}, byte_pick};
    end else begin
      case (psmad_size_e'(size))
        SZ_HALF_LO, SZ_HALF_HI: opnd = {is_signed & half_pick[HALF_W-1], half_pick};
        SZ_WORD:                word_sel = 1'b1;
        default:                bad_sel  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/psmad_madd.sv
module psmad_madd
  import psmad_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int OPND_W = DATA_W / 2 + 1,
  localparam int SUM_W  = 2 * OPND_W + 2
) (
  input  logic signed [OPND_W-1:0] op_a,
  input  logic signed [OPND_W-1:0] op_b,
  input  logic [DATA_W-1:0]        addend,
  input  logic                     res_signed,
  input  logic [1:0]               shift_sel,
  input  logic                     sat_en,
  input  logic                     force_zero,
  output logic [DATA_W-1:0]        res,
  output logic                     sat_hit
);

  localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'((64'd1 << (DATA_W-1)) - 64'd1);
  localparam logic signed [SUM_W-1:0] S_MIN = ~S_MAX;
  localparam logic signed [SUM_W-1:0] U_MAX = SUM_W'((64'd1 << DATA_W) - 64'd1);
  localparam logic signed [SUM_W-1:0] U_MIN = '0;

  logic signed [SUM_W-1:0] prod, c_ext, sum, shifted, hi_lim, lo_lim;
  logic                    over, under;

  assign prod   = op_a * op_b;
  assign c_ext  = res_signed ? {{(SUM_W-DATA_W){addend[DATA_W-1]}}, addend}
                             : {{(SUM_W-DATA_W){1'b0}}, addend};
  assign sum    = prod + c_ext;

  always_comb begin
    case (psmad_shift_e'(shift_sel))
      SH_R7:   shifted = sum >>> 7;
      SH_R15:  shifted = sum >>> 15;
      default: shifted = sum;
    endcase
  end

  assign hi_lim = res_signed ? S_MAX : U_MAX;
  assign lo_lim = res_signed ? S_MIN : U_MIN;
  assign over   = shifted > hi_lim;
  assign under  = shifted < lo_lim;

  always_comb begin
    sat_hit = 1'b0;
    if (force_zero) begin
      res = '0;
    end else if (sat_en && over) begin
      res     = hi_lim[DATA_W-1:0];
      sat_hit = 1'b1;
    end else if (sat_en && under) begin
      res     = lo_lim[DATA_W-1:0];
      sat_hit = 1'b1;
    end else begin
      res = shifted[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/psmad_unit.sv
module psmad_unit
  import psmad_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int OPND_W = HALF_W + 1,
  localparam int SEL_W  = $clog2(DATA_W / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [HALF_W-1:0] imm_b,
  input  logic [DATA_W-1:0] src_c,
  input  logic              b_from_reg,
  input  logic              a_sign,
  input  logic              b_sign,
  input  logic              a_byte,
  input  logic [SEL_W-1:0]  a_lane,
  input  logic [1:0]        a_size,
  input  logic              b_byte,
  input  logic [SEL_W-1:0]  b_lane,
  input  logic [1:0]        b_size,
  input  logic [1:0]        shift_sel,
  input  logic              sat_en,
  input  logic              flag_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal,
  output logic              flag_zero,
  output logic              flag_neg,
  output logic              flag_sat
);

  logic [OPND_W-1:0] a_op, b_reg_op, b_op;
  logic              a_word, a_bad, b_word, b_bad;
  logic              res_signed, force_zero, sat_hit;
  logic [DATA_W-1:0] res_nxt;

  // next-state values
  logic              valid_d, illegal_d, zero_d, neg_d, sat_d;
  logic              data_en, flag_upd;

  psmad_extract #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext_a (
    .src(src_a), .byte_mode(a_byte), .lane(a_lane), .size(a_size),
    .is_signed(a_sign), .opnd(a_op), .word_sel(a_word), .bad_sel(a_bad)
  );

  psmad_extract #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext_b (
    .src(src_b), .byte_mode(b_byte), .lane(b_lane), .size(b_size),
    .is_signed(b_sign), .opnd(b_reg_op), .word_sel(b_word), .bad_sel(b_bad)
  );

  assign b_op       = b_from_reg ? b_reg_op : {b_sign & imm_b[HALF_W-1], imm_b};
  assign res_signed = a_sign | b_sign;
  assign force_zero = a_word | a_bad | (b_from_reg & (b_word | b_bad));

  psmad_madd #(.DATA_W(DATA_W)) u_madd (
    .op_a(a_op), .op_b(b_op), .addend(src_c), .res_signed(res_signed),
    .shift_sel(shift_sel), .sat_en(sat_en), .force_zero(force_zero),
    .res(res_nxt), .sat_hit(sat_hit)
  );

  always_comb begin
    valid_d   = in_valid;
    data_en   = in_valid;
    flag_upd  = in_valid & flag_en;
    illegal_d = a_word | (b_from_reg & b_word);
    zero_d    = (res_nxt == '0);
    neg_d     = res_nxt[DATA_W-1];
    sat_d     = sat_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      illegal <= 1'b0;
    end else if (data_en) begin
      result  <= res_nxt;
      illegal <= illegal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_zero <= 1'b0;
      flag_neg  <= 1'b0;
      flag_sat  <= 1'b0;
    end else if (flag_upd) begin
      flag_zero <= zero_d;
      flag_neg  <= neg_d;
      flag_sat  <= sat_d;
    end
  end

endmodule

// File: rtl/psmad_check.sv
module psmad_check #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              flag_en,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal,
  input logic              flag_zero,
  input logic              flag_neg,
  input logic              flag_sat
);

  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] UMAX = {DATA_W{1'b1}};

  assert_strobe_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_spurious_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(illegal));

  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (result == '0));

  assert_flags_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && flag_en) |=> $stable({flag_zero, flag_neg, flag_sat}));

  assert_flags_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flag_en) |=> (flag_zero == (result == '0)) && (flag_neg == result[DATA_W-1]));

  assert_sat_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flag_en) |=> (!flag_sat || result == SMAX || result == SMIN || result == UMAX));

endmodule

bind psmad_unit psmad_check #(.DATA_W(DATA_W)) u_check (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flag_en(flag_en),
  .out_valid(out_valid), .result(result), .illegal(illegal),
  .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_sat(flag_sat)
);

// File: tb/psmad_unit_test.sv
module psmad_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0;
  logic [15:0] imm_b = '0;
  logic        b_from_reg = 1'b0, a_sign = 1'b0, b_sign = 1'b0;
  logic        a_byte = 1'b0, b_byte = 1'b0;
  logic [1:0]  a_lane = '0, b_lane = '0, a_size = '0, b_size = '0, shift_sel = '0;
  logic        sat_en = 1'b0, flag_en = 1'b0;
  logic        out_valid, illegal, flag_zero, flag_neg, flag_sat;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    bit          ill, z, n, s;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  bit   hz = 0, hn = 0, hs = 0;

  always #2 clk = ~clk;  // 250 MHz

  psmad_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .imm_b(imm_b), .src_c(src_c), .b_from_reg(b_from_reg), .a_sign(a_sign),
    .b_sign(b_sign), .a_byte(a_byte), .a_lane(a_lane), .a_size(a_size),
    .b_byte(b_byte), .b_lane(b_lane), .b_size(b_size), .shift_sel(shift_sel),
    .sat_en(sat_en), .flag_en(flag_en), .out_valid(out_valid), .result(result),
    .illegal(illegal), .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_sat(flag_sat)
  );

  function automatic longint pick(logic [31:0] src, bit bm, int ln, int sz, bit sg,
                                  output bit word, output bit bad);
    longint v;
    word = 0; bad = 0; v = 0;
    if (bm) begin
      v = (src >> (ln * 8)) & 32'hFF;
      if (sg && v >= 128) v = v - 256;
    end else if (sz == 0 || sz == 1) begin
      v = (sz == 1) ? (src >> 16) : (src & 32'hFFFF);
      if (sg && v >= 32768) v = v - 65536;
    end else if (sz == 2) word = 1;
    else bad = 1;
    return v;
  endfunction

  task automatic go(input logic [31:0] a, b, c, input logic [15:0] imm,
                    input bit breg, as, bs, ab, input int al, asz,
                    input bit bb, input int bl, bsz, input int sh,
                    input bit sat, fen, input string tag);
    exp_t   e;
    longint va, vb, vc, sum, hi, lo;
    bit     aw, abad, bw, bbad, rs, fz;
    @(negedge clk);
    src_a = a; src_b = b; src_c = c; imm_b = imm; b_from_reg = breg;
    a_sign = as; b_sign = bs; a_byte = ab; a_lane = 2'(al); a_size = 2'(asz);
    b_byte = bb; b_lane = 2'(bl); b_size = 2'(bsz); shift_sel = 2'(sh);
    sat_en = sat; flag_en = fen; in_valid = 1'b1;
    rs = as | bs;
    va = pick(a, ab, al, asz, as, aw, abad);
    if (breg) vb = pick(b, bb, bl, bsz, bs, bw, bbad);
    else begin
      bw = 0; bbad = 0; vb = imm;
      if (bs && vb >= 32768) vb = vb - 65536;
    end
    vc = c;
    if (rs && vc >= 64'sh80000000) vc = vc - 64'sh100000000;
    sum = va * vb + vc;
    if (sh == 1) sum = sum >>> 7;
    else if (sh == 2) sum = sum >>> 15;
    hi = rs ? 64'sh7FFFFFFF : 64'shFFFFFFFF;
    lo = rs ? -64'sh80000000 : 0;
    fz = aw | abad | (breg & (bw | bbad));
    e.s = 0;
    if (fz) e.res = '0;
    else if (sat && sum > hi) begin e.res = hi[31:0]; e.s = 1; end
    else if (sat && sum < lo) begin e.res = lo[31:0]; e.s = 1; end
    else e.res = sum[31:0];
    e.ill = aw | (breg & bw);
    if (fen) begin hz = (e.res == 0); hn = e.res[31]; hs = e.s; end
    e.z = hz; e.n = hn; e.s = hs;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected strobe, actual result=%h expected none", result);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (result !== e.res || illegal !== e.ill || flag_zero !== e.z ||
            flag_neg !== e.n || flag_sat !== e.s) begin
          errors++;
          $display("FAIL %s: actual res=%h ill=%b z=%b n=%b s=%b expected res=%h ill=%b z=%b n=%b s=%b",
                   e.tag, result, illegal, flag_zero, flag_neg, flag_sat,
                   e.res, e.ill, e.z, e.n, e.s);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R10 reset state
    if (out_valid !== 0 || result !== 0 || illegal !== 0 ||
        flag_zero !== 0 || flag_neg !== 0 || flag_sat !== 0) begin
      errors++;
      $display("FAIL R10: reset actual v=%b r=%h expected all zero", out_valid, result);
    end
    rst_n = 1'b1;
    @(negedge clk);
    //   a            b            c            imm      breg as bs ab al asz bb bl bsz sh sat fen
    go(32'h11223344, 32'hA0B0C0D0, 32'd5,       16'h0,   1, 0, 0, 1, 2, 0, 1, 3, 0, 0, 0, 1, "R1 lanes 2x3");
    go(32'h11223344, 32'hA0B0C0D0, 32'd0,       16'h0,   1, 0, 0, 1, 0, 3, 1, 1, 3, 0, 0, 1, "R1 R8 lanes 0x1, size ignored");
    go(32'h12345678, 32'h00030002, 32'd0,       16'h0,   1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, "R2 high x low");
    go(32'h12345678, 32'h00030002, 32'd7,       16'h0,   1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R2 low x high");
    go(32'h00000080, 32'h00000002, 32'd0,       16'h0,   1, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 1, "R3 signed byte");
    go(32'h00000080, 32'h00000002, 32'd0,       16'h0,   1, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 1, "R3 unsigned byte");
    go(32'h0000FFFF, 32'h80000000, 32'd0,       16'h0,   1, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0, 1, "R3 signed halves");
    go(32'h00000001, 32'h0,        32'd0,       16'hFFFF,0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R4 imm unsigned");
    go(32'h00000001, 32'h0,        32'd0,       16'hFFFF,0, 0, 1, 1, 0, 0, 0, 0, 3, 0, 0, 1, "R4 imm signed, size ignored");
    go(32'h0,        32'h0,        32'h80000000,16'h0,   0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 1, "R5 R6 unsigned addend");
    go(32'h0,        32'h0,        32'h80000000,16'h0,   0, 1, 0, 1, 0, 0, 0, 0, 0, 1, 0, 1, "R5 R6 signed addend");
    go(32'h00004000, 32'h0,        32'd0,       16'h4000,0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 1, "R6 shift 15");
    go(32'h0000FFFF, 32'h0,        32'd0,       16'h0100,0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R6 shift 7 negative");
    go(32'h00004000, 32'h0,        32'd3,       16'h4000,0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 1, "R6 code 3 no shift");
    go(32'h00007FFF, 32'h0,        32'h7FFFFFFF,16'h7FFF,0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R7 signed high clamp");
    go(32'h00007FFF, 32'h0,        32'h7FFFFFFF,16'h7FFF,0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 signed wrap");
    go(32'h00008000, 32'h0,        32'h80000000,16'h7FFF,0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R7 signed low clamp");
    go(32'h00000001, 32'h0,        32'hFFFFFFFF,16'h0001,0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1, "R7 unsigned clamp");
    go(32'h00000001, 32'h0,        32'hFFFFFFFF,16'h0001,0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R7 R11 unsigned wrap zero");
    go(32'h00050005, 32'h0,        32'd9,       16'h0003,0, 0, 0, 0, 0, 3, 0, 0, 0, 0, 0, 1, "R8 A invalid");
    go(32'h00050005, 32'h00020002, 32'd9,       16'h0,   1, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 1, "R8 B invalid");
    go(32'h00050005, 32'h0,        32'd9,       16'h0003,0, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0, 1, "R9 A word");
    go(32'h00050005, 32'h00020002, 32'd9,       16'h0,   1, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0, 1, "R9 B word");
    go(32'h00000080, 32'h00000002, 32'd0,       16'h0,   1, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 1, "R11 set neg");
    go(32'h0,        32'h0,        32'd0,       16'h0,   0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R11 flags held");
    idle();
    @(negedge clk);
    checks++;  // R10 strobe drops and result held after idle
    if (out_valid !== 1'b0 || result !== 32'h0) begin
      errors++;
      $display("FAIL R10: idle actual v=%b r=%h expected v=0 r=00000000", out_valid, result);
    end
    go(32'h00000003, 32'h0,        32'd1,       16'h0004,0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R10 after gap");
    idle();
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: pending actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule